// File: doc/BRIEF.md
# Nearest-Even Significand Rounder

This block is the last stage of a single-precision floating-point datapath. An upstream unit (aligner, adder or multiplier) delivers a sign, a biased exponent and a fraction that still carries extra bits below the 23 bits the result keeps. The rounder reduces that fraction to the result width using round-to-nearest with ties going to the even neighbour. It then packs sign, exponent and fraction into one IEEE-style word.

The increment decision uses three bits. G is the lowest bit that is kept. R is the first bit that is dropped. S is the OR of all dropped bits below R. The fraction is incremented when R is set and either G or S is set. The increment is applied to the exponent and fraction taken together as one number. So a carry out of an all-ones fraction clears the fraction and raises the exponent by one. The same carry promotes a subnormal (exponent code 0) to the smallest normal exponent. When the rounded exponent reaches the all-ones code, the result saturates to a signed infinity and an overflow flag is raised. An inexact flag reports that any dropped bit was nonzero. An input that already carries the all-ones exponent (infinity or NaN) is passed through unrounded.

The result is registered and appears one clock after the input strobe, with a valid bit alongside.

Top module: `nre_rounder`

## Requirements
- R1: The output word holds the sign in its top bit, the exponent in the next EXP_W bits and the fraction in the low FRAC_W bits; the output sign always equals the input sign.
- R2: G is in_frac[EXTRA_W], R is in_frac[EXTRA_W-1], and S is the OR of in_frac[EXTRA_W-2:0]; the kept fraction is in_frac[FRAC_W+EXTRA_W-1:EXTRA_W], and when no increment happens it appears unchanged with the input exponent.
- R3: The kept fraction is incremented exactly when R AND (G OR S) holds; an exact tie (R=1, S=0) rounds up only when G=1.
- R4: An increment of an all-ones fraction gives a zero fraction and an exponent one higher; this also holds for exponent code 0, which becomes code 1.
- R5: When the rounded exponent reaches the all-ones code, the output is a signed infinity (all-ones exponent, zero fraction) and out_overflow is 1; otherwise out_overflow is 0.
- R6: out_inexact equals R OR S for every input whose exponent is not all ones.
- R7: An input with the all-ones exponent code is passed through with its exponent and kept fraction unchanged, no increment, and out_inexact = out_overflow = 0.
- R8: out_valid is 1 exactly in the cycle after a cycle with in_valid = 1, and the result of that input is present in the same cycle.
- R9: While in_valid is 0, out_result, out_inexact and out_overflow keep their previous values.
- R10: After reset, out_valid, out_result, out_inexact and out_overflow are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input strobe |
| in_sign | input | 1 | Sign of the unrounded value |
| in_exp | input | EXP_W | Biased exponent |
| in_frac | input | FRAC_W+EXTRA_W | Fraction below the implicit leading bit, with extra low bits |
| out_valid | output | 1 | Registered result strobe |
| out_result | output | 1+EXP_W+FRAC_W | Packed rounded result |
| out_inexact | output | 1 | A nonzero bit was discarded |
| out_overflow | output | 1 | Rounding saturated to infinity |

## Verification
Three things can happen in one cycle: the tie-to-even increment, the carry that ripples from an all-ones fraction into the exponent, and saturation to infinity. All three fire on an input with the largest finite exponent, an all-ones kept fraction and R set. A reduced configuration (4-bit exponent, 4-bit fraction, 3 extra bits) is swept over every sign, exponent and fraction. This drives that collision for both signs and for tie and non-tie patterns. Each output word and both flags are compared with a reference built from integer comparison of the dropped bits against one half.

// File: rtl/nre_pkg.sv
package nre_pkg;

  typedef struct packed {
    logic g;
    logic r;
    logic s;
  } grs_t;

endpackage

// File: rtl/nre_grs.sv
module nre_grs
  import nre_pkg::*;
#(
  parameter int FRAC_W  = 23,
  parameter int EXTRA_W = 3
) (
  input  logic [FRAC_W+EXTRA_W-1:0] frac_in,
  output logic [FRAC_W-1:0]         kept,
  output grs_t                      grs
);

  assign kept  = frac_in[FRAC_W+EXTRA_W-1:EXTRA_W];
  assign grs.g = frac_in[EXTRA_W];
  assign grs.r = frac_in[EXTRA_W-1];

  generate
    if (EXTRA_W >= 2) begin : g_sticky
      assign grs.s = |frac_in[EXTRA_W-2:0];
    end else begin : g_nosticky
      assign grs.s = 1'b0;
    end
  endgenerate

endmodule

// File: rtl/nre_decide.sv
module nre_decide
  import nre_pkg::*;
(
  input  grs_t grs,
  input  logic special,
  output logic inc,
  output logic inexact
);

  always_comb begin
    if (special) begin
      inc     = 1'b0;
      inexact = 1'b0;
    end else begin
      inc     = grs.r & (grs.g | grs.s);
      inexact = grs.r | grs.s;
    end
  end

endmodule

// File: rtl/nre_pack.sv
module nre_pack #(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23
) (
  input  logic                      sign,
  input  logic [EXP_W-1:0]          exp_in,
  input  logic [FRAC_W-1:0]         kept,
  input  logic                      inc,
  input  logic                      special,
  output logic [EXP_W+FRAC_W:0]     word,
  output logic                      overflow
);

  localparam int EF_W = EXP_W + FRAC_W;

  logic [EF_W-1:0]   sum;
  logic [EXP_W-1:0]  sum_exp;
  logic [FRAC_W-1:0] sum_frac;

  assign sum      = {exp_in, kept} + {{(EF_W-1){1'b0}}, inc};
  assign sum_exp  = sum[EF_W-1:FRAC_W];
  assign sum_frac = sum[FRAC_W-1:0];

  always_comb begin
    if (special) begin
      word     = {sign, exp_in, kept};
      overflow = 1'b0;
    end else if (&sum_exp) begin
      word     = {sign, {EXP_W{1'b1}}, {FRAC_W{1'b0}}};
      overflow = 1'b1;
    end else begin
      word     = {sign, sum_exp, sum_frac};
      overflow = 1'b0;
    end
  end

endmodule

// File: rtl/nre_rounder.sv
module nre_rounder
  import nre_pkg::*;
#(
  parameter int EXP_W   = 8,
  parameter int FRAC_W  = 23,
  parameter int EXTRA_W = 3
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        in_valid,
  input  logic                        in_sign,
  input  logic [EXP_W-1:0]            in_exp,
  input  logic [FRAC_W+EXTRA_W-1:0]   in_frac,
  output logic                        out_valid,
  output logic [EXP_W+FRAC_W:0]       out_result,
  output logic                        out_inexact,
  output logic                        out_overflow
);

  localparam int WORD_W = 1 + EXP_W + FRAC_W;

  logic [FRAC_W-1:0] kept;
  grs_t              grs;
  logic              special;
  logic              inc;
  logic              inexact_c;
  logic [WORD_W-1:0] word_c;
  logic              ovf_c;

  assign special = &in_exp;

  nre_grs #(.FRAC_W(FRAC_W), .EXTRA_W(EXTRA_W)) u_grs (
    .frac_in (in_frac),
    .kept    (kept),
    .grs     (grs)
  );

  nre_decide u_dec (
    .grs     (grs),
    .special (special),
    .inc     (inc),
    .inexact (inexact_c)
  );

  nre_pack #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_pack (
    .sign     (in_sign),
    .exp_in   (in_exp),
    .kept     (kept),
    .inc      (inc),
    .special  (special),
    .word     (word_c),
    .overflow (ovf_c)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid    <= 1'b0;
      out_result   <= '0;
      out_inexact  <= 1'b0;
      out_overflow <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_result   <= word_c;
        out_inexact  <= inexact_c;
        out_overflow <= ovf_c;
      end
    end
  end

endmodule

// File: rtl/nre_rounder_chk.sv
module nre_rounder_chk #(
  parameter int EXP_W   = 8,
  parameter int FRAC_W  = 23,
  parameter int EXTRA_W = 3
) (
  input logic                        clk,
  input logic                        rst,
  input logic                        in_valid,
  input logic                        in_sign,
  input logic [EXP_W-1:0]            in_exp,
  input logic [FRAC_W+EXTRA_W-1:0]   in_frac,
  input logic                        out_valid,
  input logic [EXP_W+FRAC_W:0]       out_result,
  input logic                        out_inexact,
  input logic                        out_overflow
);

  localparam int TOP = EXP_W + FRAC_W;

  AST_VALID_RISE: assert property (@(posedge clk) disable iff (rst) in_valid |=> out_valid);   // R8
  AST_VALID_IDLE: assert property (@(posedge clk) disable iff (rst) !in_valid |=> !out_valid); // R8
  AST_HOLD_WORD: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> ($stable(out_result) && $stable(out_inexact) && $stable(out_overflow)));    // R9
  AST_SIGN_PASS: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_result[TOP] == $past(in_sign));                                          // R1
  AST_OVF_INF: assert property (@(posedge clk) disable iff (rst)
    out_overflow |-> ((&out_result[TOP-1:FRAC_W]) && (out_result[FRAC_W-1:0] == '0)));         // R5
  AST_INEXACT_RS: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !(&in_exp)) |=> out_inexact == $past(|in_frac[EXTRA_W-1:0]));                // R6
  AST_SPECIAL_QUIET: assert property (@(posedge clk) disable iff (rst)
    (in_valid && (&in_exp)) |=> (!out_inexact && !out_overflow));                              // R7

endmodule

bind nre_rounder nre_rounder_chk #(.EXP_W(EXP_W), .FRAC_W(FRAC_W), .EXTRA_W(EXTRA_W)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .in_valid     (in_valid),
  .in_sign      (in_sign),
  .in_exp       (in_exp),
  .in_frac      (in_frac),
  .out_valid    (out_valid),
  .out_result   (out_result),
  .out_inexact  (out_inexact),
  .out_overflow (out_overflow)
);

// File: tb/sim_nre_rounder.sv
`timescale 1ns/1ps
module sim_nre_rounder;

  localparam int EW = 4;
  localparam int FW = 4;
  localparam int XW = 3;
  localparam int IW = FW + XW;
  localparam int WW = 1 + EW + FW;
  localparam int EMAX = (1 << EW) - 1;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          in_valid = 1'b0;
  logic          in_sign = 1'b0;
  logic [EW-1:0] in_exp = '0;
  logic [IW-1:0] in_frac = '0;
  logic          out_valid;
  logic [WW-1:0] out_result;
  logic          out_inexact;
  logic          out_overflow;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;

  always #10 clk = ~clk;

  nre_rounder #(.EXP_W(EW), .FRAC_W(FW), .EXTRA_W(XW)) u0 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_sign(in_sign),
    .in_exp(in_exp), .in_frac(in_frac), .out_valid(out_valid),
    .out_result(out_result), .out_inexact(out_inexact), .out_overflow(out_overflow)
  );

  task automatic chk(input string tag, input int act, input int exp_v);
    n_chk++;
    if (act != exp_v) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp_v);
    end
  endtask

  task automatic apply(input int s, input int e, input int f);
    int kept, low, half, up, tot, re, rf, ex_word, ex_inx, ex_ovf;
    string tag;
    in_valid = 1'b1; in_sign = s[0]; in_exp = e[EW-1:0]; in_frac = f[IW-1:0];
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    kept = f >> XW;
    low  = f & ((1 << XW) - 1);
    half = 1 << (XW - 1);
    up   = (low > half || (low == half && (kept % 2) == 1)) ? 1 : 0;
    if (e == EMAX) begin
      ex_word = (s << (EW + FW)) | (e << FW) | kept; ex_inx = 0; ex_ovf = 0; tag = "R7";
    end else begin
      tot = e * (1 << FW) + kept + up;
      re = tot >> FW; rf = tot % (1 << FW);
      ex_inx = (low != 0) ? 1 : 0;
      if (re == EMAX) begin
        ex_word = (s << (EW + FW)) | (EMAX << FW); ex_ovf = 1; tag = "R5";
      end else begin
        ex_word = (s << (EW + FW)) | (re << FW) | rf; ex_ovf = 0;
        tag = (re != e) ? "R4" : (up != 0 ? "R3" : "R2");
      end
    end
    chk("R8 valid", int'(out_valid), 1);
    chk(tag, int'(out_result), ex_word);
    chk("R1 sign", int'(out_result[WW-1]), s);
    chk("R6 inexact", int'(out_inexact), ex_inx);
    chk("R5 overflow", int'(out_overflow), ex_ovf);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++; n_chk++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin : stim
    logic [WW-1:0] held;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R10 reset state
    chk("R10 valid", int'(out_valid), 0);
    chk("R10 result", int'(out_result), 0);
    chk("R10 inexact", int'(out_inexact), 0);
    chk("R10 overflow", int'(out_overflow), 0);
    // Directed corner: largest finite exponent, all-ones, tie with G=1 -> infinity (R5, R3, R4 at once)
    apply(1, EMAX - 1, (1 << IW) - 1 - ((1 << (XW - 1)) - 1));
    // Tie with G=0 stays (R3)
    apply(0, 5, (4'b0110 << XW) | (1 << (XW - 1)));
    // Subnormal promotion (R4)
    apply(0, 0, ((1 << FW) - 1) << XW | (1 << (XW - 1)) | 1);
    // Exhaustive sweep
    for (int s = 0; s < 2; s++)
      for (int e = 0; e <= EMAX; e++)
        for (int f = 0; f < (1 << IW); f++)
          apply(s, e, f);
    // R9 hold while idle
    held = out_result;
    @(negedge clk);
    in_exp = 3; in_frac = 7'h55; in_sign = 1'b1;
    @(posedge clk);
    @(negedge clk);
    chk("R9 idle valid", int'(out_valid), 0);
    chk("R9 hold result", int'(out_result), int'(held));
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule